// File: doc/BRIEF.md
# Exception and Interrupt Control Unit

This block keeps the system-control state of a 32-bit core and sequences entry into the event handler and return from it. The pipeline can report a synchronous fault as a 5-bit event code. With it come the address of the instruction involved, an optional data address and a branch-delay flag. The pipeline also supplies a level-sensitive vector of external interrupt lines and a return strobe. On entry the block redirects fetch to one fixed handler address, records the return address and the event details, and raises the exception-level flag. While that flag is set, further interrupts are held off. The return strobe sends fetch back to the saved address and lowers the flag.

Software reaches four registers through a read port and a write port used by the move-from and move-to instructions. These are the faulting data address (number 8), the status word (number 12), the cause word (number 13) and the saved return address (number 14). The block also drives a level telling the core that events may be taken. Flushing, decode and the handler software belong to the surrounding core.

Top module: `exc_ctl_top`

## Requirements
- R1: After reset the status, cause, return-address and faulting-address registers all read 0, `redirectValid` is 0 and `eventsAllowed` is 0.
- R2: Register numbers 8, 12, 13 and 14 read the faulting address, status, cause and return address; every other number reads 0. Status bits: 15..8 interrupt mask, 4 kernel/user, 1 exception level (EXL), 0 global enable; all others read 0. Cause bits: 31 branch-delay, 15..8 pending interrupts, 6..2 event code; all others read 0.
- R3: A move-to write changes the register from the next clock edge. Status keeps only bits 15..8, 4, 1 and 0. Cause keeps only bits 31 and 6..2. The return address keeps all 32 bits. Writes to number 8 and to unmapped numbers change nothing.
- R4: On entry, `redirectValid` is 1 and `redirectPc` is 0x80000180 in the same cycle. From the next edge EXL is 1, Cause[6:2] holds the event code, Cause[31] holds `excInDelay`, and the return address holds `excPc`.
- R5: The faulting-address register loads `excDataAddr` only for synchronous codes 4 (load address fault) and 5 (store address fault); any other entry leaves it unchanged.
- R6: When `eretStrobe` is 1 without `excReq`, `redirectValid` is 1 and `redirectPc` equals the saved return address in that cycle, and EXL is 0 from the next edge.
- R7: Cause[15:8] shows `irqLines` as sampled at the previous clock edge.
- R8: An interrupt entry happens only when the global enable is 1, EXL is 0 and some pending bit has its mask bit set. It records event code 0 and `excPc` as the return address.
- R9: `eventsAllowed` equals global enable AND NOT EXL. While EXL is 1, no interrupt entry takes place.
- R10: `excReq` outranks a return strobe and an interrupt in the same cycle. A return strobe outranks an interrupt.
- R11: A move-to write in the same cycle as an entry or a return is dropped.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rstN | input | 1 | Active-low synchronous reset |
| excReq | input | 1 | Synchronous fault request |
| excCode | input | 5 | Event code of the fault |
| excPc | input | 32 | Address of the faulting or current instruction |
| excDataAddr | input | 32 | Offending data address |
| excInDelay | input | 1 | Instruction sits in a branch-delay slot |
| irqLines | input | 8 | External interrupt request levels |
| eretStrobe | input | 1 | Return-from-handler strobe |
| regRdAddr | input | 5 | Move-from register number |
| regRdData | output | 32 | Move-from read data |
| regWrEn | input | 1 | Move-to write enable |
| regWrAddr | input | 5 | Move-to register number |
| regWrData | input | 32 | Move-to write data |
| redirectValid | output | 1 | Fetch redirect this cycle |
| redirectPc | output | 32 | Redirect target |
| eventsAllowed | output | 1 | Global enable set and EXL clear |

## Verification
The bench builds the block with its defaults: eight interrupt lines and handler entry 0x80000180. With eight lines, the full mask and pending bytes come into play, so masking a single line against a single pending line can be tested. All-ones writes can then show exactly which status and cause bits survive. Directed sequences cover every ordering between fault, return and interrupt in the same cycle. A random phase then mixes writes, faults, returns and interrupt levels against the reference model.

// File: rtl/exc_ctl_pkg.sv
package exc_ctl_pkg;
  localparam int WORD_W = 32;
  localparam int CODE_W = 5;
  localparam int RNUM_W = 5;

  localparam logic [RNUM_W-1:0] REG_BADADDR = 5'd8;
  localparam logic [RNUM_W-1:0] REG_STATUS  = 5'd12;
  localparam logic [RNUM_W-1:0] REG_CAUSE   = 5'd13;
  localparam logic [RNUM_W-1:0] REG_RETADDR = 5'd14;

  localparam logic [CODE_W-1:0] CODE_INTR  = 5'd0;
  localparam logic [CODE_W-1:0] CODE_LDADR = 5'd4;
  localparam logic [CODE_W-1:0] CODE_STADR = 5'd5;

  // strobes from the sequencer to the register datapath
  typedef struct packed {
    logic enter;
    logic isIrq;
    logic leave;
    logic loadBad;
    logic wrStatus;
    logic wrCause;
    logic wrRet;
  } excStrobe_t;
endpackage

// File: rtl/exc_ctl_seq.sv
module exc_ctl_seq
  import exc_ctl_pkg::*;
#(
  parameter int NUM_IRQ = 8
) (
  input  logic                clk,
  input  logic                rstN,
  input  logic                excReq,
  input  logic [CODE_W-1:0]   excCode,
  input  logic                eretStrobe,
  input  logic                regWrEn,
  input  logic [RNUM_W-1:0]   regWrAddr,
  input  logic                statusIe,
  input  logic                statusExl,
  input  logic [NUM_IRQ-1:0]  pendMasked,
  output excStrobe_t          stb,
  output logic [CODE_W-1:0]   entryCode,
  output logic                redirectValid,
  output logic                eventsAllowed
);
  logic irqOk;
  logic quiet;

  always_comb begin
    irqOk         = statusIe && !statusExl && (|pendMasked);
    stb.leave     = eretStrobe && !excReq;
    stb.enter     = excReq || (irqOk && !eretStrobe);
    stb.isIrq     = stb.enter && !excReq;
    stb.loadBad   = excReq && (excCode == CODE_LDADR || excCode == CODE_STADR);
    quiet         = regWrEn && !stb.enter && !stb.leave;
    stb.wrStatus  = quiet && (regWrAddr == REG_STATUS);
    stb.wrCause   = quiet && (regWrAddr == REG_CAUSE);
    stb.wrRet     = quiet && (regWrAddr == REG_RETADDR);
    entryCode     = excReq ? excCode : CODE_INTR;
    redirectValid = stb.enter || stb.leave;
    eventsAllowed = statusIe && !statusExl;
  end

  // R10
  enter_leave_excl_chk: assert property (@(posedge clk) disable iff (!rstN)
    $onehot0({stb.enter, stb.leave}));

  // R8
  irq_gate_chk: assert property (@(posedge clk) disable iff (!rstN)
    (stb.enter && !excReq) |-> (statusIe && !statusExl));

  // R11
  write_drop_chk: assert property (@(posedge clk) disable iff (!rstN)
    redirectValid |-> !(stb.wrStatus || stb.wrCause || stb.wrRet));
endmodule

// File: rtl/exc_ctl_path.sv
module exc_ctl_path
  import exc_ctl_pkg::*;
#(
  parameter int                 NUM_IRQ    = 8,
  parameter logic [WORD_W-1:0]  HANDLER_PC = 32'h8000_0180
) (
  input  logic                clk,
  input  logic                rstN,
  input  excStrobe_t          stb,
  input  logic [CODE_W-1:0]   entryCode,
  input  logic [WORD_W-1:0]   excPc,
  input  logic [WORD_W-1:0]   excDataAddr,
  input  logic                excInDelay,
  input  logic [NUM_IRQ-1:0]  irqLines,
  input  logic [RNUM_W-1:0]   regRdAddr,
  output logic [WORD_W-1:0]   regRdData,
  input  logic [WORD_W-1:0]   regWrData,
  output logic [WORD_W-1:0]   redirectPc,
  output logic                statusIe,
  output logic                statusExl,
  output logic [NUM_IRQ-1:0]  pendMasked
);
  localparam int IRQ_LO = 8;

  logic [WORD_W-1:0]  badQ, retQ;
  logic [NUM_IRQ-1:0] maskQ, pendQ;
  logic               kuQ, exlQ, ieQ, bdQ;
  logic [CODE_W-1:0]  codeQ;
  logic [WORD_W-1:0]  statusW, causeW;

  always_ff @(posedge clk) begin
    if (!rstN) begin
      badQ  <= '0;
      retQ  <= '0;
      maskQ <= '0;
      pendQ <= '0;
      kuQ   <= 1'b0;
      exlQ  <= 1'b0;
      ieQ   <= 1'b0;
      bdQ   <= 1'b0;
      codeQ <= '0;
    end else begin
      pendQ <= irqLines;
      if (stb.enter) begin
        exlQ  <= 1'b1;
        codeQ <= entryCode;
        bdQ   <= excInDelay;
        retQ  <= excPc;
        if (stb.loadBad) badQ <= excDataAddr;
      end else if (stb.leave) begin
        exlQ <= 1'b0;
      end else begin
        if (stb.wrStatus) begin
          maskQ <= regWrData[IRQ_LO +: NUM_IRQ];
          kuQ   <= regWrData[4];
          exlQ  <= regWrData[1];
          ieQ   <= regWrData[0];
        end
        if (stb.wrCause) begin
          bdQ   <= regWrData[31];
          codeQ <= regWrData[6:2];
        end
        if (stb.wrRet) retQ <= regWrData;
      end
    end
  end

  always_comb begin
    statusW = '0;
    statusW[IRQ_LO +: NUM_IRQ] = maskQ;
    statusW[4] = kuQ;
    statusW[1] = exlQ;
    statusW[0] = ieQ;
    causeW = '0;
    causeW[31] = bdQ;
    causeW[IRQ_LO +: NUM_IRQ] = pendQ;
    causeW[6:2] = codeQ;
    case (regRdAddr)
      REG_BADADDR: regRdData = badQ;
      REG_STATUS:  regRdData = statusW;
      REG_CAUSE:   regRdData = causeW;
      REG_RETADDR: regRdData = retQ;
      default:     regRdData = '0;
    endcase
    redirectPc = stb.enter ? HANDLER_PC : retQ;
    statusIe   = ieQ;
    statusExl  = exlQ;
    pendMasked = pendQ & maskQ;
  end

  // R4
  entry_sets_exl_chk: assert property (@(posedge clk) disable iff (!rstN)
    stb.enter |=> exlQ);

  // R4
  entry_target_chk: assert property (@(posedge clk) disable iff (!rstN)
    stb.enter |-> redirectPc == HANDLER_PC);

  // R6
  leave_clears_exl_chk: assert property (@(posedge clk) disable iff (!rstN)
    stb.leave |=> !exlQ);

  // R5
  badaddr_hold_chk: assert property (@(posedge clk) disable iff (!rstN)
    !stb.loadBad |=> $stable(badQ));
endmodule

// File: rtl/exc_ctl_top.sv
module exc_ctl_top
  import exc_ctl_pkg::*;
#(
  parameter int                 NUM_IRQ    = 8,
  parameter logic [WORD_W-1:0]  HANDLER_PC = 32'h8000_0180
) (
  input  logic               clk,
  input  logic               rstN,
  input  logic               excReq,
  input  logic [4:0]         excCode,
  input  logic [31:0]        excPc,
  input  logic [31:0]        excDataAddr,
  input  logic               excInDelay,
  input  logic [NUM_IRQ-1:0] irqLines,
  input  logic               eretStrobe,
  input  logic [4:0]         regRdAddr,
  output logic [31:0]        regRdData,
  input  logic               regWrEn,
  input  logic [4:0]         regWrAddr,
  input  logic [31:0]        regWrData,
  output logic               redirectValid,
  output logic [31:0]        redirectPc,
  output logic               eventsAllowed
);
  excStrobe_t         stb;
  logic [CODE_W-1:0]  entryCode;
  logic               statusIe, statusExl;
  logic [NUM_IRQ-1:0] pendMasked;

  exc_ctl_seq #(.NUM_IRQ(NUM_IRQ)) uSeq (
    .clk(clk), .rstN(rstN), .excReq(excReq), .excCode(excCode),
    .eretStrobe(eretStrobe), .regWrEn(regWrEn), .regWrAddr(regWrAddr),
    .statusIe(statusIe), .statusExl(statusExl), .pendMasked(pendMasked),
    .stb(stb), .entryCode(entryCode), .redirectValid(redirectValid),
    .eventsAllowed(eventsAllowed)
  );

  exc_ctl_path #(.NUM_IRQ(NUM_IRQ), .HANDLER_PC(HANDLER_PC)) uPath (
    .clk(clk), .rstN(rstN), .stb(stb), .entryCode(entryCode),
    .excPc(excPc), .excDataAddr(excDataAddr), .excInDelay(excInDelay),
    .irqLines(irqLines), .regRdAddr(regRdAddr), .regRdData(regRdData),
    .regWrData(regWrData), .redirectPc(redirectPc),
    .statusIe(statusIe), .statusExl(statusExl), .pendMasked(pendMasked)
  );
endmodule

// File: tb/sim_exc_ctl_top.sv
`timescale 1ns/1ps
module sim_exc_ctl_top;
  logic        clk = 1'b0;
  logic        rstN = 1'b0;
  logic        excReq = 1'b0;
  logic [4:0]  excCode = '0;
  logic [31:0] excPc = '0;
  logic [31:0] excDataAddr = '0;
  logic        excInDelay = 1'b0;
  logic [7:0]  irqLines = '0;
  logic        eretStrobe = 1'b0;
  logic [4:0]  regRdAddr = '0;
  logic [31:0] regRdData;
  logic        regWrEn = 1'b0;
  logic [4:0]  regWrAddr = '0;
  logic [31:0] regWrData = '0;
  logic        redirectValid;
  logic [31:0] redirectPc;
  logic        eventsAllowed;

  int total = 0;
  int bad = 0;

  // reference state
  logic [31:0] mStat = '0, mCause = '0, mEpc = '0, mBad = '0;
  logic [7:0]  mPend = '0;
  localparam logic [31:0] HANDLER = 32'h8000_0180;

  always #4 clk = ~clk;

  exc_ctl_top u0 (
    .clk(clk), .rstN(rstN), .excReq(excReq), .excCode(excCode), .excPc(excPc),
    .excDataAddr(excDataAddr), .excInDelay(excInDelay), .irqLines(irqLines),
    .eretStrobe(eretStrobe), .regRdAddr(regRdAddr), .regRdData(regRdData),
    .regWrEn(regWrEn), .regWrAddr(regWrAddr), .regWrData(regWrData),
    .redirectValid(redirectValid), .redirectPc(redirectPc),
    .eventsAllowed(eventsAllowed)
  );

  task automatic check(input string tag, input string what,
                       input logic [31:0] act, input logic [31:0] exp);
    total++;
    if (act !== exp) begin
      bad++;
      $display("FAIL %s %s actual=%h expected=%h", tag, what, act, exp);
    end
  endtask

  function automatic logic [31:0] modelRead(input logic [4:0] a);
    case (a)
      5'd8:  return mBad;
      5'd12: return mStat;
      5'd13: return mCause | {16'd0, mPend, 8'd0};
      5'd14: return mEpc;
      default: return 32'd0;
    endcase
  endfunction

  // called just after a falling edge with inputs already set
  task automatic step(input string tag);
    logic hit, enter, leave;
    logic [4:0] c;
    #2;
    hit   = mStat[0] && !mStat[1] && ((mPend & mStat[15:8]) != 0);
    enter = excReq || (hit && !eretStrobe);
    leave = eretStrobe && !excReq;
    check(tag, "redirectValid", {31'd0, redirectValid}, {31'd0, enter || leave});
    if (enter || leave)
      check(tag, "redirectPc", redirectPc, enter ? HANDLER : mEpc);
    check(tag, "eventsAllowed", {31'd0, eventsAllowed}, {31'd0, mStat[0] && !mStat[1]});
    check(tag, "regRdData", regRdData, modelRead(regRdAddr));
    @(posedge clk);
    c = excReq ? excCode : 5'd0;
    if (enter) begin
      mStat  = mStat | 32'h2;
      mCause = {excInDelay, 31'd0} | {25'd0, c, 2'b00};
      mEpc   = excPc;
      if (excReq && (excCode == 5'd4 || excCode == 5'd5)) mBad = excDataAddr;
    end else if (leave) begin
      mStat = mStat & ~32'h2;
    end else if (regWrEn) begin
      if (regWrAddr == 5'd12) mStat = regWrData & 32'h0000_FF13;
      if (regWrAddr == 5'd13) mCause = regWrData & 32'h8000_007C;
      if (regWrAddr == 5'd14) mEpc = regWrData;
    end
    mPend = irqLines;
    @(negedge clk);
  endtask

  task automatic quiet();
    excReq = 0; eretStrobe = 0; regWrEn = 0; excInDelay = 0;
  endtask

  task automatic wr(input logic [4:0] a, input logic [31:0] d, input string tag);
    quiet(); regWrEn = 1; regWrAddr = a; regWrData = d; regRdAddr = a;
    step(tag);
    regWrEn = 0; step(tag);
  endtask

  task automatic fault(input logic [4:0] c, input logic [31:0] pc,
                       input logic [31:0] da, input logic d, input string tag);
    quiet(); excReq = 1; excCode = c; excPc = pc; excDataAddr = da; excInDelay = d;
    step(tag);
    quiet();
  endtask

  task automatic readAll(input string tag);
    quiet();
    regRdAddr = 5'd8;  step(tag);
    regRdAddr = 5'd12; step(tag);
    regRdAddr = 5'd13; step(tag);
    regRdAddr = 5'd14; step(tag);
  endtask

  task automatic ret(input string tag);
    quiet(); eretStrobe = 1; step(tag); quiet();
  endtask

  initial begin
    repeat (200000) @(posedge clk);
    total++; bad++;
    $display("FAIL watchdog expired");
    $display("test done: total=%0d bad=%0d", total, bad);
    $finish;
  end

  initial begin
    repeat (3) @(posedge clk);
    @(negedge clk);
    #2;
    check("R1", "rv in reset", {31'd0, redirectValid}, 32'd0);
    rstN = 1;
    @(negedge clk);
    readAll("R1");
    regRdAddr = 5'd0; step("R2");
    regRdAddr = 5'd9; step("R2");
    wr(5'd12, 32'hFFFF_FFFF, "R3");
    wr(5'd12, 32'h0000_FF01, "R9");
    wr(5'd14, 32'h1234_5678, "R3");
    wr(5'd13, 32'hFFFF_FFFF, "R3");
    wr(5'd8,  32'hDEAD_BEEF, "R3");
    wr(5'd3,  32'hFFFF_FFFF, "R2");
    wr(5'd13, 32'h0, "R3");
    fault(5'd4, 32'h0040_0010, 32'h0000_0010, 1'b0, "R4");
    readAll("R5");
    ret("R6");
    regRdAddr = 5'd12; step("R6");
    fault(5'd12, 32'h0040_0020, 32'h0000_0999, 1'b1, "R4");
    readAll("R5");
    ret("R6");
    fault(5'd5, 32'h0040_0030, 32'h0000_0403, 1'b0, "R5");
    regRdAddr = 5'd8; step("R5");
    ret("R6");
    // interrupts
    irqLines = 8'h08; regRdAddr = 5'd13; step("R7");
    step("R8");
    step("R9"); step("R9");
    ret("R10");
    step("R8");
    irqLines = 8'h00; step("R8");
    ret("R6");
    wr(5'd12, 32'h0000_0101, "R3");
    irqLines = 8'h08; step("R8"); step("R8"); step("R8");
    irqLines = 8'h01; step("R8"); step("R8");
    irqLines = 8'h00; ret("R6");
    wr(5'd12, 32'h0000_FF00, "R9");
    irqLines = 8'hFF; step("R9"); step("R9");
    wr(5'd12, 32'h0000_FF01, "R3");
    irqLines = 8'h00; step("R8");
    ret("R6");
    // priority
    irqLines = 8'hFF; regRdAddr = 5'd13; step("R7");
    fault(5'd13, 32'h0040_0100, 32'h0, 1'b0, "R10");
    step("R10");
    irqLines = 8'h00;
    quiet(); excReq = 1; eretStrobe = 1; excCode = 5'd9; excPc = 32'h0040_0200;
    step("R10");
    quiet(); regRdAddr = 5'd12; step("R10");
    ret("R6");
    // write overridden by entry / return
    quiet(); excReq = 1; excCode = 5'd8; excPc = 32'h0040_0300;
    regWrEn = 1; regWrAddr = 5'd14; regWrData = 32'hAAAA_5555;
    regRdAddr = 5'd14; step("R11");
    quiet(); step("R11");
    eretStrobe = 1; regWrEn = 1; regWrAddr = 5'd12; regWrData = 32'h0000_0000;
    regRdAddr = 5'd12; step("R11");
    quiet(); step("R11");
    // mixed random traffic against the model
    for (int i = 0; i < 600; i++) begin
      logic [4:0] codes [10] = '{5'd4, 5'd5, 5'd8, 5'd9, 5'd10, 5'd12, 5'd13, 5'd15, 5'd16, 5'd17};
      logic [4:0] regs [5] = '{5'd8, 5'd12, 5'd13, 5'd14, 5'd2};
      excReq      = ($urandom % 12) == 0;
      excCode     = codes[$urandom % 10];
      excPc       = $urandom;
      excDataAddr = $urandom;
      excInDelay  = $urandom % 2;
      eretStrobe  = ($urandom % 10) == 0;
      irqLines    = (($urandom % 4) == 0) ? 8'($urandom) : 8'h00;
      regWrEn     = ($urandom % 4) == 0;
      regWrAddr   = regs[$urandom % 5];
      regWrData   = $urandom;
      regRdAddr   = regs[$urandom % 5];
      step("RND");
    end
    $display("test done: total=%0d bad=%0d", total, bad);
    $finish;
  end
endmodule